// File: doc/BRIEF.md
# Memory-Mapped LPC I/O Cycle Bridge

This block gives a processor that has no native I/O address space a way to reach legacy port-mapped peripherals on a four-bit LPC link. Software programs a batch through a small bank of 32-bit registers. It sets how many cycles to run, the direction, whether the port stays fixed or steps up, and the first port number. For writes it also loads the bytes to send. It then sets the launch bit. A sequencer runs one single-byte LPC I/O cycle after another on the LAD nibble bus and the frame strobe. It honours the peripheral's wait codes, and it abandons the batch on an error code or on an over-long wait.

When the batch ends, the status register shows that the engine is idle and whether every cycle completed. Bytes captured by read cycles are drained one per access from a read-data register, in the order they arrived. An interrupt flag is raised at every batch end. The flag is cleared by writing one to it, and it reaches the `irq` pin only when its enable bit is set. The bridge and the link share one clock.

Top module: `mmio_lpc_bridge`

## Requirements
- R1: After reset the status register (offset 0x04) reads 1: idle bit 0 set, success bit 1 clear. The `irq` pin is low, `lframe_n` is high and `lad_oe` is low.
- R2: The register offsets are: launch 0x00, status 0x04, interrupt 0x08 (bit 0 enable, bit 1 flag), length 0x10, command 0x14 (bit 0 direction with 1 = write, bit 3 fixed port), port 0x20 (16 bits), write data 0x24 and read data 0x28. A length written above 16 reads back as 16.
- R3: Writing bit 0 of the launch register while idle runs exactly as many cycles as the length register holds. A length of 0 completes at once with success and no cycle on the link.
- R4: Each cycle is one clock of `lframe_n` low with LAD = 0000, then a type nibble (0010 for write, 0000 for read), then the 16-bit port as four nibbles with the most significant first. A write then sends two data nibbles, low first. Two turnaround clocks follow, then SYNC. A read then takes two data nibbles, low first. Two final turnaround clocks end the cycle. With no wait codes, a cycle lasts 13 clocks.
- R5: With command bit 3 clear, the port rises by one per cycle and wraps at 16 bits. With bit 3 set, every cycle of the batch uses the same port.
- R6: Bytes written to 0x24 before a launch are sent in the order written. Each read of 0x28 returns the next byte captured by the last batch, in capture order.
- R7: A SYNC of 0101 or 0110 holds the cycle one more clock. Up to 256 such wait clocks per cycle still allow success, each adding one clock to the batch.
- R8: A SYNC of 1010, any other unknown code, or a 257th wait code ends the batch at once. The engine returns to idle with the success bit clear, and no further cycle of the batch starts.
- R9: The success bit is clear from launch until the batch ends. It is set only when every requested cycle has completed.
- R10: Every batch end sets the interrupt flag, whether the batch succeeded or failed. Writing 1 to bit 1 of 0x08 clears the flag. `irq` is high exactly while both the flag and the enable bit are set.
- R11: While busy, writes to length, command, port, write data, interrupt and launch are ignored. A launch issued while busy does not add a batch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the register side and the link |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the read queue at 0x28 |
| reg_addr | input | AW (8) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Batch-end interrupt, gated by its enable |
| lframe_n | output | 1 | Frame strobe, low for the start nibble |
| lad_out | output | 4 | Nibble driven onto LAD |
| lad_oe | output | 1 | Drive enable for LAD |
| lad_in | input | 4 | Nibble sampled from LAD |

## Verification
The bench runs its own peripheral model on the nibble bus. The model decodes each frame, logs the port, type and byte, and answers with a chosen number of wait codes or an error code. The corner cases it targets are these:
- The port wraps from 0xFFFF to 0x0000. A design with a narrow or mis-ordered address would log the wrong ports.
- A cycle with exactly 256 waits must succeed, while one with too many must fail. An off-by-one wait limit flips one of these two outcomes.
- An error code must stop the batch after its first cycle. A design that carries on would log extra frames.
- During a busy window the bench writes the length, the write queue and the launch bit. A design that accepts them would show a changed length, an extra batch, or a corrupted byte in the next batch.

// File: rtl/mmio_lpc_bridge.sv
module mmio_lpc_bridge #(
  parameter int MAX_OPS  = 16,
  parameter int WAIT_MAX = 256,
  parameter int AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          lframe_n,
  output logic [3:0]    lad_out,
  output logic          lad_oe,
  input  logic [3:0]    lad_in
);
  localparam int CW = $clog2(MAX_OPS + 1);
  localparam int IW = (MAX_OPS > 1) ? $clog2(MAX_OPS) : 1;
  localparam int WW = $clog2(WAIT_MAX + 1);
  localparam logic [AW-1:0] O_GO   = AW'(8'h00);
  localparam logic [AW-1:0] O_STAT = AW'(8'h04);
  localparam logic [AW-1:0] O_IRQ  = AW'(8'h08);
  localparam logic [AW-1:0] O_LEN  = AW'(8'h10);
  localparam logic [AW-1:0] O_CMD  = AW'(8'h14);
  localparam logic [AW-1:0] O_PORT = AW'(8'h20);
  localparam logic [AW-1:0] O_WDAT = AW'(8'h24);
  localparam logic [AW-1:0] O_RDAT = AW'(8'h28);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_CTD, S_ADDR, S_WDAT, S_TAR1, S_SYNC, S_RDAT, S_TAR2
  } st_t;

  st_t           st;
  logic [CW-1:0] len_q, idx, wcnt, rptr;
  logic          dir_q, same_q, ok_q, irq_en, irq_st;
  logic [15:0]   port_q, cur_port;
  logic [1:0]    nib;
  logic [WW-1:0] wait_q;
  logic [7:0]    wq [MAX_OPS];
  logic [7:0]    rq [MAX_OPS];
  logic          busy, wr_ok, go, last_cyc;
  logic [IW-1:0] ix;

  assign busy     = (st != S_IDLE);
  assign wr_ok    = reg_wr && !busy;
  assign go       = wr_ok && (reg_addr == O_GO) && reg_wdata[0];
  assign last_cyc = (idx + CW'(1)) == len_q;
  assign ix       = idx[IW-1:0];
  assign lframe_n = (st != S_START);
  assign lad_oe   = (st inside {S_START, S_CTD, S_ADDR, S_WDAT}) || (st == S_TAR1 && nib == 2'd0);
  assign irq      = irq_en & irq_st;

  always_comb begin
    lad_out = 4'hF;
    case (st)
      S_START: lad_out = 4'h0;
      S_CTD:   lad_out = {2'b00, dir_q, 1'b0};
      S_ADDR:
        case (nib)
          2'd0:    lad_out = cur_port[15:12];
          2'd1:    lad_out = cur_port[11:8];
          2'd2:    lad_out = cur_port[7:4];
          default: lad_out = cur_port[3:0];
        endcase
      S_WDAT:  lad_out = nib[0] ? wq[ix][7:4] : wq[ix][3:0];
      default: ;
    endcase
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      O_STAT: reg_rdata[1:0]    = {ok_q, !busy};
      O_IRQ:  reg_rdata[1:0]    = {irq_st, irq_en};
      O_LEN:  reg_rdata[CW-1:0] = len_q;
      O_CMD:  reg_rdata[3:0]    = {same_q, 2'b00, dir_q};
      O_PORT: reg_rdata[15:0]   = port_q;
      O_RDAT: if (rptr < CW'(MAX_OPS)) reg_rdata[7:0] = rq[rptr[IW-1:0]];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      len_q    <= '0;
      idx      <= '0;
      wcnt     <= '0;
      rptr     <= '0;
      dir_q    <= 1'b0;
      same_q   <= 1'b0;
      ok_q     <= 1'b0;
      irq_en   <= 1'b0;
      irq_st   <= 1'b0;
      port_q   <= '0;
      cur_port <= '0;
      nib      <= '0;
      wait_q   <= '0;
    end else begin
      if (reg_rd && reg_addr == O_RDAT && rptr < CW'(MAX_OPS)) rptr <= rptr + CW'(1);
      if (wr_ok) begin
        case (reg_addr)
          O_LEN:  len_q <= (reg_wdata > 32'(MAX_OPS)) ? CW'(MAX_OPS) : reg_wdata[CW-1:0];
          O_CMD:  begin dir_q <= reg_wdata[0]; same_q <= reg_wdata[3]; end
          O_PORT: port_q <= reg_wdata[15:0];
          O_WDAT: if (wcnt < CW'(MAX_OPS)) wcnt <= wcnt + CW'(1);
          O_IRQ:  begin irq_en <= reg_wdata[0]; if (reg_wdata[1]) irq_st <= 1'b0; end
          default: ;
        endcase
      end
      if (go) begin
        wcnt     <= '0;
        rptr     <= '0;
        idx      <= '0;
        nib      <= '0;
        cur_port <= port_q;
        if (len_q == '0) begin
          ok_q   <= 1'b1;
          irq_st <= 1'b1;
        end else begin
          ok_q <= 1'b0;
          st   <= S_START;
        end
      end
      case (st)
        S_START: st <= S_CTD;
        S_CTD: begin
          st  <= S_ADDR;
          nib <= '0;
        end
        S_ADDR: begin
          nib <= nib + 2'd1;
          if (nib == 2'd3) st <= dir_q ? S_WDAT : S_TAR1;
        end
        S_WDAT: begin
          nib <= nib + 2'd1;
          if (nib[0]) begin st <= S_TAR1; nib <= '0; end
        end
        S_TAR1: begin
          nib <= nib + 2'd1;
          if (nib[0]) begin st <= S_SYNC; nib <= '0; wait_q <= '0; end
        end
        S_SYNC: begin
          if (lad_in == 4'h0) begin
            st  <= dir_q ? S_TAR2 : S_RDAT;
            nib <= '0;
          end else if ((lad_in == 4'h5 || lad_in == 4'h6) && wait_q != WW'(WAIT_MAX)) begin
            wait_q <= wait_q + WW'(1);
          end else begin
            st     <= S_IDLE;
            irq_st <= 1'b1;
          end
        end
        S_RDAT: begin
          nib <= nib + 2'd1;
          if (nib[0]) begin st <= S_TAR2; nib <= '0; end
        end
        S_TAR2: begin
          nib <= nib + 2'd1;
          if (nib[0]) begin
            nib <= '0;
            if (last_cyc) begin
              st     <= S_IDLE;
              ok_q   <= 1'b1;
              irq_st <= 1'b1;
            end else begin
              st  <= S_START;
              idx <= idx + CW'(1);
              if (!same_q) cur_port <= cur_port + 16'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && reg_addr == O_WDAT && wcnt < CW'(MAX_OPS)) wq[wcnt[IW-1:0]] <= reg_wdata[7:0];
    if (st == S_RDAT) begin
      if (nib[0]) rq[ix][7:4] <= lad_in;
      else        rq[ix][3:0] <= lad_in;
    end
  end
endmodule

// File: rtl/mmio_lpc_bridge_chk.sv
module mmio_lpc_bridge_chk #(
  parameter int MAX_OPS = 16,
  parameter int CW      = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lframe_n,
  input logic          lad_oe,
  input logic [3:0]    lad_out,
  input logic          busy,
  input logic          ok_q,
  input logic          irq_st,
  input logic [CW-1:0] len_q
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lframe_n && !lad_oe));
  p_len_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= CW'(MAX_OPS));
  p_frame_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |-> (lad_oe && lad_out == 4'h0));
  p_frame_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |=> lframe_n);
  p_ok_low_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ok_q);
  p_end_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq_st);
  p_len_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(len_q));
endmodule

bind mmio_lpc_bridge mmio_lpc_bridge_chk #(.MAX_OPS(MAX_OPS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lframe_n(lframe_n), .lad_oe(lad_oe), .lad_out(lad_out),
  .busy(busy), .ok_q(ok_q), .irq_st(irq_st), .len_q(len_q)
);

// File: tb/mmio_lpc_bridge_test.sv
`timescale 1ns/1ps
module mmio_lpc_bridge_test;
  logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, lframe_n, lad_oe;
  logic [3:0]  lad_out;
  logic [3:0]  lad_in = 4'hF;

  mmio_lpc_bridge uut (.*);

  always #2.5 clk = ~clk;

  localparam logic [7:0] A_GO = 8'h00, A_STAT = 8'h04, A_IRQ = 8'h08, A_LEN = 8'h10;
  localparam logic [7:0] A_CMD = 8'h14, A_PORT = 8'h20, A_WDAT = 8'h24, A_RDAT = 8'h28;

  // {write, fixed, len, port, waits, error, expect_ok}
  localparam int NV = 6;
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 1'b0, 5'd3,  16'h0060, 9'd0, 1'b0, 1'b1},
    {1'b1, 1'b1, 5'd4,  16'h00E4, 9'd2, 1'b0, 1'b1},
    {1'b0, 1'b0, 5'd2,  16'h02F8, 9'd0, 1'b0, 1'b1},
    {1'b0, 1'b1, 5'd16, 16'h00E5, 9'd1, 1'b0, 1'b1},
    {1'b0, 1'b0, 5'd3,  16'h0080, 9'd0, 1'b1, 1'b0},
    {1'b1, 1'b0, 5'd16, 16'hFFF8, 9'd0, 1'b0, 1'b1}
  };

  int checks = 0, errors = 0, exp_rseq = 0;

  // peripheral model
  int nwait = 0, ph = 0, w = 0, sp = 0, cur = 0, rseq = 0, log_n = 0;
  bit perr = 1'b0, act = 1'b0, wr_c = 1'b0, sdone = 1'b0;
  logic [3:0]  ct;
  logic [15:0] pport;
  logic [7:0]  pdat, rbyte;
  logic [15:0] log_port [256];
  logic [7:0]  log_data [256];
  logic [3:0]  log_ct   [256];

  always @(negedge clk) begin
    if (!act) begin
      lad_in = 4'hF;
      if (rst_n && !lframe_n && lad_oe && lad_out == 4'h0) begin
        act = 1'b1; ph = 0; w = 0; sdone = 1'b0; pport = '0;
      end
    end else begin
      ph++;
      lad_in = 4'hF;
      if (ph == 1) begin ct = lad_out; wr_c = lad_out[1]; end
      else if (ph <= 5) pport = {pport[11:0], lad_out};
      if (ph == 5) begin cur = log_n; log_port[cur] = pport; log_ct[cur] = ct; log_n++; end
      if (wr_c && ph == 6) pdat[3:0] = lad_out;
      if (wr_c && ph == 7) begin pdat[7:4] = lad_out; log_data[cur] = pdat; end
      if (!sdone && ph >= (wr_c ? 10 : 8)) begin
        if (w < nwait) begin lad_in = w[0] ? 4'h6 : 4'h5; w++; end
        else begin
          lad_in = perr ? 4'hA : 4'h0;
          sdone = 1'b1; sp = ph;
          rbyte = pport[7:0] + 8'(rseq);
        end
      end else if (sdone) begin
        if (perr) act = 1'b0;
        else if (!wr_c && ph == sp + 1) lad_in = rbyte[3:0];
        else if (!wr_c && ph == sp + 2) lad_in = rbyte[7:4];
        else if (ph == sp + (wr_c ? 2 : 4)) begin act = 1'b0; if (!wr_c) rseq++; end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] dat);
    @(negedge clk); reg_addr = a; reg_wdata = dat; reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input bit pop);
    @(negedge clk); reg_addr = a; reg_rd = pop; #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic poll(output int bc);
    bc = 0;
    @(negedge clk); reg_addr = A_STAT; #1;
    while (!reg_rdata[0] && bc < 5000) begin bc++; @(negedge clk); #1; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bc, base;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(A_STAT, d, 0); chk("R1 status after reset", d, 32'h1);
    chk("R1 pins after reset", {29'd0, irq, lframe_n, lad_oe}, 32'b010);

    wr(A_LEN, 32'd20); rd(A_LEN, d, 0); chk("R2 length clamp", d, 32'd16);
    wr(A_CMD, 32'h9);  rd(A_CMD, d, 0); chk("R2 command readback", d, 32'h9);
    wr(A_PORT, 32'h1234); rd(A_PORT, d, 0); chk("R2 port readback", d, 32'h1234);
    wr(A_IRQ, 32'h1);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      logic [15:0] ep;
      int len;
      v = VEC[i];
      len = int'(v[31:27]);
      nwait = int'(v[10:2]); perr = v[1];
      wr(A_LEN, 32'(len));
      wr(A_CMD, {28'd0, v[32], 2'b00, v[33]});
      wr(A_PORT, {16'd0, v[26:11]});
      if (v[33]) for (int k = 0; k < len; k++) wr(A_WDAT, {24'd0, 4'(i), 4'(k)});
      base = log_n;
      wr(A_GO, 32'h1);
      poll(bc);
      rd(A_STAT, d, 0); chk("R9 R8 batch outcome", d, {30'd0, v[0], 1'b1});
      if (v[0]) chk("R4 R7 busy clocks", 32'(bc), 32'(len * (13 + nwait)));
      chk("R3 R8 cycles on link", 32'(log_n - base), v[0] ? 32'(len) : 32'd1);
      for (int k = 0; k < (v[0] ? len : 0); k++) begin
        ep = v[32] ? v[26:11] : v[26:11] + 16'(k);
        chk("R5 port of cycle", {16'd0, log_port[base + k]}, {16'd0, ep});
        chk("R4 type nibble", {28'd0, log_ct[base + k]}, v[33] ? 32'h2 : 32'h0);
        if (v[33]) chk("R6 write byte order", {24'd0, log_data[base + k]}, {24'd0, 4'(i), 4'(k)});
        else begin
          rd(A_RDAT, d, 1);
          chk("R6 read byte order", d, {24'd0, 8'(ep[7:0] + 8'(exp_rseq))});
          exp_rseq++;
        end
      end
      chk("R10 irq at batch end", {31'd0, irq}, 32'd1);
      wr(A_IRQ, 32'h3);
      chk("R10 irq cleared by one", {31'd0, irq}, 32'd0);
      repeat (4) @(negedge clk);
    end

    nwait = 0; perr = 1'b0;
    wr(A_LEN, 32'd0); base = log_n;
    wr(A_GO, 32'h1); poll(bc);
    rd(A_STAT, d, 0); chk("R3 zero length succeeds", d, 32'h3);
    chk("R3 zero length no wait", 32'(bc), 32'd0);
    chk("R3 zero length no cycle", 32'(log_n - base), 32'd0);
    wr(A_IRQ, 32'h3);

    nwait = 256;
    wr(A_LEN, 32'd1); wr(A_CMD, 32'h1); wr(A_PORT, 32'h70); wr(A_WDAT, 32'h5C);
    base = log_n; wr(A_GO, 32'h1); poll(bc);
    rd(A_STAT, d, 0); chk("R7 256 waits succeed", d, 32'h3);
    chk("R7 256 waits clocks", 32'(bc), 32'd269);
    chk("R7 byte after waits", {24'd0, log_data[base]}, 32'h5C);
    wr(A_IRQ, 32'h3);

    nwait = 300;
    wr(A_LEN, 32'd2); wr(A_WDAT, 32'h11); wr(A_WDAT, 32'h22);
    base = log_n; wr(A_GO, 32'h1); poll(bc);
    rd(A_STAT, d, 0); chk("R8 wait timeout fails", d, 32'h1);
    chk("R8 timeout stops batch", 32'(log_n - base), 32'd1);
    chk("R10 irq on failed batch", {31'd0, irq}, 32'd1);
    repeat (100) @(negedge clk);
    wr(A_IRQ, 32'h3);

    nwait = 20;
    wr(A_LEN, 32'd4); wr(A_CMD, 32'h1); wr(A_PORT, 32'h40);
    for (int k = 0; k < 4; k++) wr(A_WDAT, 32'hD0 + 32'(k));
    base = log_n;
    wr(A_GO, 32'h1);
    wr(A_LEN, 32'd2); wr(A_WDAT, 32'hEE); wr(A_GO, 32'h1);
    poll(bc);
    rd(A_LEN, d, 0); chk("R11 length write while busy ignored", d, 32'd4);
    chk("R11 launch while busy ignored", 32'(log_n - base), 32'd4);
    nwait = 0;
    wr(A_LEN, 32'd1); base = log_n;
    wr(A_GO, 32'h1); poll(bc);
    chk("R11 data write while busy ignored", {24'd0, log_data[base]}, 32'hD0);
    chk("R3 single cycle batch", 32'(log_n - base), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule